// File: doc/BRIEF.md
# PWM Output Channel with General-Purpose Pin Fallback

This block drives one pin. It can produce a pulse-width modulated waveform, or it can act as a plain general-purpose I/O when modulation is off. An 8-bit prescaler divides the system clock into a channel tick. A period counter runs on that tick, and a compare against the active pulse value shapes an output flip-flop. Before the pin sees that flip-flop, a polarity bit can invert it. The period and pulse values can be staged and then take effect at the next period boundary, or they can take effect the moment they are written.

Software reaches the block through a small synchronous register port with one control word, one period register, one pulse register and a read-only status word. The status word holds the synchronised level of the pin. A freeze input halts the channel while a freeze-enable bit in the control word is set. With that bit clear, the freeze input is ignored.

Top module: `pwm_io_channel`

## Requirements
- R1: After reset, every control field reads 0, the period and pulse registers read 0, and `pin_oe` and `pin_out` are 0.
- R2: The control word has enable at bit 0, polarity at bit 1, direction at bit 2, immediate-update at bit 3, freeze-enable at bit 4 and prescaler modulus M at bits 15:8. The addresses are 0 control, 1 period, 2 pulse and 3 status. A read returns the addressed register one clock after `rd_addr` is presented.
- R3: While enabled and not frozen, the channel advances once every M+1 clocks.
- R4: A new modulus takes effect only when the prescaler reaches its terminal count, or in the write that sets enable from 0 to 1, which loads the written modulus.
- R5: With period P and pulse D, the waveform repeats every max(P,1) channel ticks. Before polarity it is high for min(D, max(P,1)) ticks, starting at the beginning of each period. D = 0 gives a constant low.
- R6: With immediate-update clear, period and pulse writes are staged and take effect at the next period rollover. Enabling the channel also loads the staged values.
- R7: With immediate-update set, a pulse or period write takes effect in the clock after the write.
- R8: With freeze-enable set and `freeze_in` high, the channel holds its state and `pin_out` does not change. With freeze-enable clear, `freeze_in` has no effect.
- R9: While enabled, `pin_oe` is 1, and `pin_out` is the waveform inverted when polarity is 1.
- R10: While disabled, `pin_oe` equals the direction bit, and `pin_out` drives the polarity bit as a static level.
- R11: Bit 0 of the status word reflects `pin_in` through a two-stage synchroniser. Writes to the status address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Registered read data |
| freeze_in | input | 1 | Freeze request |
| pin_in | input | 1 | Level currently on the pin |
| pin_out | output | 1 | Registered pin drive value |
| pin_oe | output | 1 | Registered pin output enable |

## Verification
A corrupted prescaler or period count shows up within one waveform period. It appears as a wrong count of high clocks or of rising edges over a window of whole periods. A staging error, meaning an active register loaded too early or too late, changes the length of the high pulse that is in progress when the write arrives, so it is visible on the very next falling edge. A wrong pin-mode decode shows on `pin_oe` or `pin_out` two clocks after the control write.

// File: rtl/pwm_io_pkg.sv
package pwm_io_pkg;

  localparam int PSC_W = 8;
  localparam int CTRL_W = 16;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_PERIOD = 2'd1,
    ADDR_PULSE  = 2'd2,
    ADDR_STATUS = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic [2:0]       rsvd;
    logic             frz_en;
    logic             imm;
    logic             dir;
    logic             pol;
    logic             en;
  } ctrl_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_io_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              pin_sync,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  per_buf_o,
  output logic [CNT_W-1:0]  pul_buf_o,
  output logic              per_wr_o,
  output logic              pul_wr_o,
  output logic              en_rise_o,
  output logic [PSC_W-1:0]  start_psc_o,
  output logic [DATA_W-1:0] rd_data_o
);

  ctrl_t             ctrl_q;
  ctrl_t             ctrl_wr;
  logic [CNT_W-1:0]  per_q;
  logic [CNT_W-1:0]  pul_q;
  logic              ctrl_wr_s;
  logic [DATA_W-1:0] rd_mux;

  assign ctrl_wr     = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign ctrl_wr_s   = wr_en && (wr_addr == ADDR_CTRL);
  assign per_wr_o    = wr_en && (wr_addr == ADDR_PERIOD);
  assign pul_wr_o    = wr_en && (wr_addr == ADDR_PULSE);
  assign en_rise_o   = ctrl_wr_s && ctrl_wr.en && !ctrl_q.en;
  assign start_psc_o = ctrl_wr.psc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      per_q  <= '0;
      pul_q  <= '0;
    end else begin
      if (ctrl_wr_s) begin
        ctrl_q      <= ctrl_wr;
        ctrl_q.rsvd <= '0;
      end
      if (per_wr_o) per_q <= wr_data[CNT_W-1:0];
      if (pul_wr_o) pul_q <= wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(rd_addr))
      ADDR_CTRL:   rd_mux[CTRL_W-1:0] = ctrl_q;
      ADDR_PERIOD: rd_mux[CNT_W-1:0]  = per_q;
      ADDR_PULSE:  rd_mux[CNT_W-1:0]  = pul_q;
      default:     rd_mux[0]          = pin_sync;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_mux;
  end

  assign ctrl_o    = ctrl_q;
  assign per_buf_o = per_q;
  assign pul_buf_o = pul_q;

  // R11
  status_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_STATUS) |=> ($stable(ctrl_q) && $stable(per_q) && $stable(pul_q)));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_io_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [PSC_W-1:0] load_val,
  input  logic [PSC_W-1:0] modulus,
  output logic             tick_o
);

  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] last_mod_q;

  assign tick_o = run && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      last_mod_q <= '0;
    end else if (load) begin
      cnt_q      <= load_val;
      last_mod_q <= load_val;
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_q      <= modulus;
        last_mod_q <= modulus;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R4
  psc_within_mod_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_mod_q);

  // R3
  psc_steps_down_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             imm,
  input  logic             per_wr,
  input  logic             pul_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] per_buf,
  input  logic [CNT_W-1:0] pul_buf,
  output logic             pwm_o
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_act_q;
  logic [CNT_W-1:0] pul_act_q;
  logic             ff_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             rollover;

  assign cnt_inc  = cnt_q + 1'b1;
  assign rollover = (EXT_W'(cnt_q) + EXT_W'(1)) >= EXT_W'(per_act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      per_act_q <= '0;
      pul_act_q <= '0;
      ff_q      <= 1'b0;
    end else if (start) begin
      cnt_q     <= '0;
      per_act_q <= per_buf;
      pul_act_q <= pul_buf;
      ff_q      <= (pul_buf != '0);
    end else begin
      if (tick) begin
        if (rollover) begin
          cnt_q     <= '0;
          per_act_q <= per_buf;
          pul_act_q <= pul_buf;
          ff_q      <= (pul_buf != '0);
        end else begin
          cnt_q <= cnt_inc;
          if (cnt_inc == pul_act_q) ff_q <= 1'b0;
        end
      end
      if (imm && per_wr) per_act_q <= wdata;
      if (imm && pul_wr) pul_act_q <= wdata;
    end
  end

  assign pwm_o = ff_q;

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(cnt_q));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !start && !rollover) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R7
  imm_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (imm && pul_wr && !start) |=> (pul_act_q == $past(wdata)));

endmodule

// File: rtl/pwm_pin.sv
module pwm_pin #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pol,
  input  logic dir,
  input  logic pwm,
  input  logic pin_in,
  output logic pin_out_o,
  output logic pin_oe_o,
  output logic pin_sync_o
);

  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      end
    end
  endgenerate

  assign pin_sync_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out_o <= 1'b0;
      pin_oe_o  <= 1'b0;
    end else begin
      pin_out_o <= en ? (pwm ^ pol) : pol;
      pin_oe_o  <= en | dir;
    end
  end

  // R9
  en_drives_chk: assert property (@(posedge clk) disable iff (rst)
    $past(en) |-> pin_oe_o);

  // R10
  gpio_in_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!en && !dir) |-> !pin_oe_o);

  // R10
  gpio_level_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> (pin_out_o == $past(pol)));

endmodule

// File: rtl/pwm_io_channel.sv
module pwm_io_channel
  import pwm_io_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              freeze_in,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] per_buf;
  logic [CNT_W-1:0] pul_buf;
  logic             per_wr;
  logic             pul_wr;
  logic             en_rise;
  logic [PSC_W-1:0] start_psc;
  logic             pin_sync;
  logic             halted;
  logic             run;
  logic             tick;
  logic             pwm;

  assign halted = ctrl.frz_en && freeze_in;
  assign run    = ctrl.en && !halted;

  pwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pin_sync(pin_sync), .ctrl_o(ctrl), .per_buf_o(per_buf),
    .pul_buf_o(pul_buf), .per_wr_o(per_wr), .pul_wr_o(pul_wr), .en_rise_o(en_rise),
    .start_psc_o(start_psc), .rd_data_o(rd_data)
  );

  pwm_prescaler psc_i (
    .clk(clk), .rst(rst), .run(run), .load(en_rise), .load_val(start_psc),
    .modulus(ctrl.psc), .tick_o(tick)
  );

  pwm_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk(clk), .rst(rst), .tick(tick), .start(en_rise), .imm(ctrl.imm),
    .per_wr(per_wr), .pul_wr(pul_wr), .wdata(wr_data[CNT_W-1:0]),
    .per_buf(per_buf), .pul_buf(pul_buf), .pwm_o(pwm)
  );

  pwm_pin #(.SYNC_STAGES(SYNC_STAGES)) pin_i (
    .clk(clk), .rst(rst), .en(ctrl.en), .pol(ctrl.pol), .dir(ctrl.dir), .pwm(pwm),
    .pin_in(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe), .pin_sync_o(pin_sync)
  );

  // R8
  freeze_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !tick);

endmodule

// File: tb/pwm_io_channel_tb.sv
module pwm_io_channel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          freeze_in = 1'b0;
  logic          pin_in = 1'b0;
  logic          pin_out;
  logic          pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_io_channel dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .freeze_in(freeze_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [15:0] ctl(int psc, bit frz, bit imm, bit dir, bit pol, bit en);
    return {psc[7:0], 3'b000, frz, imm, dir, pol, en};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    rd_addr = a[1:0];
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(int cyc, output int hi, output int ed);
    logic prev;
    hi = 0; ed = 0; prev = pin_out;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pin_out) hi++;
      if (pin_out && !prev) ed++;
      prev = pin_out;
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = pin_out;
    forever begin
      @(negedge clk);
      if (pin_out && !prev) break;
      prev = pin_out;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int v, hi, ed, pc, h, eff, hl;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 period", v, 0);
    rd(2, v); chk("R1 pulse", v, 0);

    // R2 register readback
    wr(1, 16'h00a5); wr(2, 16'h0033);
    rd(1, v); chk("R2 period readback", v, 16'h00a5);
    rd(2, v); chk("R2 pulse readback", v, 16'h0033);

    // R10 disabled pin modes
    wr(0, ctl(0, 0, 0, 1, 1, 0)); idle(2);
    chk("R10 oe when dir=1", pin_oe, 1);
    chk("R10 level pol=1", pin_out, 1);
    wr(0, ctl(0, 0, 0, 1, 0, 0)); idle(2);
    chk("R10 level pol=0", pin_out, 0);
    wr(0, ctl(0, 0, 0, 0, 1, 0)); idle(2);
    chk("R10 oe when dir=0", pin_oe, 0);

    // R11 pin status sync and ignored status writes
    pin_in = 1'b1; idle(3);
    rd(3, v); chk("R11 status high", v & 1, 1);
    wr(3, 16'hffff);
    rd(0, v); chk("R11 ctrl unchanged", v, ctl(0, 0, 0, 0, 1, 0));
    rd(1, v); chk("R11 period unchanged", v, 16'h00a5);
    pin_in = 1'b0; idle(3);
    rd(3, v); chk("R11 status low", v & 1, 0);

    // R3 R5 R6 R9 sweep: modulus, period, pulse, polarity
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < 6; p++) begin
        for (int d = 0; d <= p + 1; d++) begin
          bit pol;
          pol = (m == 1);
          wr(0, ctl(0, 0, 0, 0, 0, 0));
          wr(1, p); wr(2, d);
          wr(0, ctl(m, 0, 0, 0, pol, 1));
          eff = (p < 1) ? 1 : p;
          pc  = eff * (m + 1);
          h   = ((d < eff) ? d : eff) * (m + 1);
          idle(2 * pc + 4);
          chk("R9 oe enabled", pin_oe, 1);
          measure(3 * pc, hi, ed);
          chk("R3 R5 R9 high clocks", hi, pol ? 3 * (pc - h) : 3 * h);
          chk("R3 R5 rising edges", ed, (h > 0 && h < pc) ? 3 : 0);
        end
      end
    end

    // R6 staged pulse: in-flight pulse keeps old width
    wr(0, ctl(0, 0, 0, 0, 0, 0));
    wr(1, 200); wr(2, 100);
    wr(0, ctl(0, 0, 0, 0, 0, 1));
    wait_rise();
    hl = 1;
    wr(2, 20); hl += 2;
    forever begin @(negedge clk); if (pin_out) hl++; else break; end
    chk("R6 staged current pulse", hl, 100);
    wait_rise();
    hl = 1;
    forever begin @(negedge clk); if (pin_out) hl++; else break; end
    chk("R6 staged next pulse", hl, 20);

    // R7 immediate pulse
    wr(0, ctl(0, 0, 0, 0, 0, 0));
    wr(2, 100);
    wr(0, ctl(0, 0, 1, 0, 0, 1));
    wait_rise();
    hl = 1;
    wr(2, 20); hl += 2;
    forever begin @(negedge clk); if (pin_out) hl++; else break; end
    chk("R7 immediate pulse", hl, 20);

    // R4 modulus change waits for terminal count
    wr(0, ctl(0, 0, 0, 0, 0, 0));
    wr(1, 2); wr(2, 1);
    wr(0, ctl(40, 0, 0, 0, 0, 1));
    wait_rise();
    hl = 1;
    wr(0, ctl(0, 0, 0, 0, 0, 1)); hl += 2;
    forever begin @(negedge clk); if (pin_out) hl++; else break; end
    chk("R4 old modulus finishes", hl, 41);
    hl = 1;
    forever begin @(negedge clk); if (!pin_out) hl++; else break; end
    chk("R4 new modulus low phase", hl, 1);

    // R8 freeze
    wr(0, ctl(0, 0, 0, 0, 0, 0));
    wr(1, 5); wr(2, 2);
    wr(0, ctl(0, 1, 0, 0, 0, 1));
    idle(12);
    freeze_in = 1'b1;
    idle(3);
    begin
      logic s; int chg;
      s = pin_out; chg = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (pin_out != s) chg++; end
      chk("R8 frozen output stable", chg, 0);
    end
    freeze_in = 1'b0; idle(12);
    measure(15, hi, ed);
    chk("R8 resumed high clocks", hi, 6);
    wr(0, ctl(0, 0, 0, 0, 0, 1));
    freeze_in = 1'b1; idle(12);
    measure(15, hi, ed);
    chk("R8 freeze ignored high clocks", hi, 6);
    chk("R8 freeze ignored edges", ed, 3);
    freeze_in = 1'b0;

    finish_run();
  end

endmodule